// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked, single-port static memory with a 32-bit word made of four byte lanes. All control inputs are sampled on the rising clock edge. An access is started by one of two address strobes. The processor-side strobe always opens with a read. The controller-side strobe may write on its own cycle. Once a burst is open, an advance input steps a two-bit counter through four consecutive words and then wraps back to the base. When advance is released, the burst is held on its current word.

Reads are pipelined. The output register shows the word two edges after its address was sampled. A data-valid flag qualifies the output and stands in for a three-state bus. The flag drops when the output enable is released or when the access was a write, a deselect or an idle cycle. Byte lanes can be written one at a time, all together through a single global write input, or all together when every lane select is active.

Top module: `sburst_sram`

## Requirements
- R1: A synchronous active-high reset clears the burst state and the read pipeline. `rvalid` is low after the reset edge, and a released reset does not resume any earlier burst.
- R2: The chip is selected only when `en1_n`=0, `en2`=1 and `en3_n`=0. Any cycle without selection performs no access, ignores both strobes and ends the open burst, so `rvalid` is low for the data slot of that cycle.
- R3: A processor strobe (`strobe_cpu_n`=0) on a selected cycle loads `addr` as the base and reads it, ignoring all write controls. A later advance cycle of that burst may write.
- R4: A controller strobe (`strobe_ctl_n`=0, processor strobe high) on a selected cycle loads `addr` and writes it in the same cycle when a write is requested. Following advance cycles with a write request extend the burst write.
- R5: While a burst is open, each selected cycle with no strobe and `step_n`=0 moves to the next word. The two low address bits count up modulo 4, so base+3 is followed by the base, and the upper address bits stay unchanged.
- R6: A selected cycle with no strobe and `step_n`=1 repeats the access at the same address.
- R7: A strobe during an open burst replaces the base address and restarts the burst from the new word.
- R8: With `wr_all_n`=1 and `lane_wr_en_n`=0, byte lane i (bits 8i+7..8i) is written only if `lane_sel_n[i]`=0, and the other lanes keep their contents. With `wr_all_n`=1 and `lane_wr_en_n`=1, nothing is written.
- R9: A full-word write takes place when `wr_all_n`=0, whatever the lane controls, or when `lane_wr_en_n`=0 with all four `lane_sel_n` bits low.
- R10: For a read whose address is sampled on edge N, `rdata` holds that word and `rvalid` is high after edge N+1.
- R11: `out_en_n`=1 forces `rvalid` low and `rdata` to zero at once, without waiting for a clock edge. Returning it to 0 shows the registered read word again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| strobe_cpu_n | input | 1 | Processor-side burst start, active low, read only |
| strobe_ctl_n | input | 1 | Controller-side burst start, active low |
| step_n | input | 1 | Burst advance, active low; high holds the burst |
| en1_n | input | 1 | Chip enable, active low |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Global full-word write, active low |
| lane_wr_en_n | input | 1 | Per-lane write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low, bit i for lane i |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid, stands in for the driven bus |

## Verification
The bench targets the wrap from base+3 back to the base inside a four-word group. A counter that carried into the upper address bits would read a word from the next group. Write controls are applied on a processor-strobe cycle and the word is then read back. A design that honoured that write would return the new data instead of the old. It also checks that a deselect closes the burst, so a later advance cycle with no strobe stays idle and does not resume. Partial-lane writes are checked byte by byte, and the output enable is toggled between clock edges to show that it acts without waiting for a clock edge.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              step_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic              act;
  logic [ADDR_W-1:0] cur_a;
  logic              rd_p;
  logic [ADDR_W-1:0] rd_a;
  logic              vld_q;
  logic [DATA_W-1:0] dout_q;

  logic              sel;
  logic              go_cpu, go_ctl, go_cont, access, wr, rd;
  logic [ADDR_W-1:0] acc_a;
  logic [LANES-1:0]  lane_we;

  assign sel     = ~en1_n & en2 & ~en3_n;
  assign go_cpu  = sel & ~strobe_cpu_n;
  assign go_ctl  = sel & strobe_cpu_n & ~strobe_ctl_n;
  assign go_cont = sel & strobe_cpu_n & strobe_ctl_n & act;
  assign access  = go_cpu | go_ctl | go_cont;

  always_comb begin
    if (go_cpu || go_ctl)
      acc_a = addr;
    else if (!step_n)
      acc_a = {cur_a[ADDR_W-1:2], cur_a[1:0] + 2'd1};
    else
      acc_a = cur_a;
  end

  assign lane_we = !wr_all_n     ? {LANES{1'b1}} :
                   !lane_wr_en_n ? ~lane_sel_n   : '0;

  assign wr = access & ~go_cpu & (|lane_we);
  assign rd = access & ~wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= 1'b0;
      rd_p  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      act   <= access;
      rd_p  <= rd;
      vld_q <= rd_p;
    end
  end

  always_ff @(posedge clk) begin
    if (access) cur_a <= acc_a;
    rd_a   <= acc_a;
    dout_q <= mem[rd_a];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr && lane_we[i])
        mem[acc_a][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  assign rvalid = vld_q & ~out_en_n;
  assign rdata  = rvalid ? dout_q : '0;

endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_i,
  input logic              act_i,
  input logic [ADDR_W-1:0] cur_a_i,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              step_n,
  input logic              out_en_n,
  input logic              rvalid
);

  logic cont_cyc;
  assign cont_cyc = act_i & sel_i & strobe_cpu_n & strobe_ctl_n;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !rvalid);

  a_r2_valid_needs_select: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(sel_i, 2));

  a_r10_cpu_read_latency: assert property (@(posedge clk) disable iff (rst)
    (sel_i && !strobe_cpu_n) |=> ##1 (rvalid || out_en_n));

  a_r6_hold_on_suspend: assert property (@(posedge clk) disable iff (rst)
    (cont_cyc && step_n) |=> $stable(cur_a_i));

  a_r5_step_in_group: assert property (@(posedge clk) disable iff (rst)
    (cont_cyc && !step_n) |=>
      (cur_a_i[ADDR_W-1:2] == $past(cur_a_i[ADDR_W-1:2])) &&
      (cur_a_i[1:0] == 2'($past(cur_a_i[1:0]) + 2'd1)));

endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sel_i(sel), .act_i(act), .cur_a_i(cur_a),
  .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
  .step_n(step_n), .out_en_n(out_en_n), .rvalid(rvalid)
);

// File: tb/tb_sburst_sram.sv
`timescale 1ns/100ps
module tb_sburst_sram;
  localparam int AW = 6;

  logic clk = 0;
  logic rst;
  logic [AW-1:0] addr;
  logic strobe_cpu_n, strobe_ctl_n, step_n, en1_n, en2, en3_n;
  logic wr_all_n, lane_wr_en_n, out_en_n;
  logic [3:0] lane_sel_n;
  logic [31:0] wdata, rdata;
  logic rvalid;

  int checks = 0, errors = 0;
  logic [31:0] shadow [64];

  localparam logic [37:0] VEC [8] = '{
    {6'h00, 32'h0A0B0C0D}, {6'h01, 32'h11111111}, {6'h20, 32'hCAFE0020},
    {6'h21, 32'hCAFE0021}, {6'h3F, 32'hFFFF003F}, {6'h3C, 32'h1234003C},
    {6'h07, 32'h77770007}, {6'h15, 32'h55550015}};

  sburst_sram #(.ADDR_W(AW)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic step(); @(posedge clk); #1; endtask

  task automatic idle();
    strobe_cpu_n = 1; strobe_ctl_n = 1; step_n = 1;
    en1_n = 0; en2 = 1; en3_n = 0;
    wr_all_n = 1; lane_wr_en_n = 1; lane_sel_n = 4'hF; out_en_n = 0;
    wdata = '0; addr = '0;
  endtask

  task automatic check(string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_word(string req, logic [31:0] exp);
    check(req, {rvalid, rdata}, {1'b1, exp});
  endtask

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d,
                                        logic g_n, logic b_n, logic [3:0] s_n);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++)
      if (!g_n || (!b_n && !s_n[i])) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic ctl_write(logic [AW-1:0] a, logic [31:0] d,
                           logic g_n, logic b_n, logic [3:0] s_n);
    strobe_ctl_n = 0; addr = a; wdata = d;
    wr_all_n = g_n; lane_wr_en_n = b_n; lane_sel_n = s_n;
    step();
    shadow[a] = merge(shadow[a], d, g_n, b_n, s_n);
    idle();
  endtask

  task automatic cpu_read(string req, logic [AW-1:0] a);
    strobe_cpu_n = 0; addr = a;
    step();
    idle();
    step();
    expect_word(req, shadow[a]);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    step(); step();
    check("R1 reset valid low", {32'b0, rvalid}, 33'd0);
    rst = 0;
    step();
    check("R1 idle after reset", {32'b0, rvalid}, 33'd0);

    // R4 / R10: table of single writes, then single reads
    for (int i = 0; i < 8; i++) ctl_write(VEC[i][37:32], VEC[i][31:0], 0, 1, 4'hF);
    for (int i = 0; i < 8; i++) cpu_read("R10 table read", VEC[i][37:32]);

    for (int i = 0; i < 4; i++) ctl_write(6'h10 + 6'(i), 32'hB0B00010 + i, 0, 1, 4'hF);

    // R5: wrap inside the group, upper bits kept
    strobe_cpu_n = 0; addr = 6'h12; step(); idle(); step_n = 0;
    step(); expect_word("R5 beat base", shadow[6'h12]);
    step(); expect_word("R5 beat +1", shadow[6'h13]);
    step(); expect_word("R5 wrap +2", shadow[6'h10]);
    step(); expect_word("R5 wrap +3", shadow[6'h11]);
    step_n = 1;
    step(); expect_word("R5 back to base", shadow[6'h12]);

    // R6: suspend holds the address
    idle(); strobe_cpu_n = 0; addr = 6'h10; step(); idle(); step_n = 0;
    step(); expect_word("R6 first", shadow[6'h10]);
    step_n = 1;
    step(); expect_word("R6 advanced", shadow[6'h11]);
    step(); expect_word("R6 held", shadow[6'h11]);
    step_n = 0;
    step(); expect_word("R6 held again", shadow[6'h11]);
    step(); expect_word("R6 resumed", shadow[6'h12]);

    // R7: new strobe mid-burst restarts
    idle(); strobe_cpu_n = 0; addr = 6'h10; step(); idle(); step_n = 0;
    step();
    strobe_ctl_n = 0; addr = 6'h20;
    step(); expect_word("R7 old burst", shadow[6'h11]);
    strobe_ctl_n = 1;
    step(); expect_word("R7 new base", shadow[6'h20]);
    step_n = 1;
    step(); expect_word("R7 new base+1", shadow[6'h21]);

    // R2: deselect ends the burst; strobe while deselected ignored
    idle(); strobe_cpu_n = 0; addr = 6'h10; step(); idle();
    en2 = 0;
    step(); expect_word("R2 before deselect", shadow[6'h10]);
    en2 = 1; step_n = 0;
    step(); check("R2 deselect slot", {32'b0, rvalid}, 33'd0);
    step(); check("R2 burst closed", {32'b0, rvalid}, 33'd0);
    idle(); en3_n = 1; strobe_cpu_n = 0; addr = 6'h01;
    step(); idle();
    step(); check("R2 strobe ignored", {32'b0, rvalid}, 33'd0);
    step(); check("R2 still idle", {32'b0, rvalid}, 33'd0);

    // R3: processor strobe ignores writes; later advance cycle writes
    strobe_cpu_n = 0; addr = 6'h07; wr_all_n = 0; wdata = 32'hDEADBEEF;
    step(); idle();
    step(); expect_word("R3 write ignored", shadow[6'h07]);
    step_n = 0; wr_all_n = 0; wdata = 32'h0404AAAA;
    step(); shadow[6'h04] = 32'h0404AAAA; idle();
    cpu_read("R3 unchanged word", 6'h07);
    cpu_read("R3 continuation write", 6'h04);

    // R4: extended burst write
    ctl_write(6'h30, 32'h30303030, 0, 1, 4'hF);
    idle(); strobe_ctl_n = 0; addr = 6'h30; wr_all_n = 0; wdata = 32'hA0A0A030; step();
    shadow[6'h30] = 32'hA0A0A030;
    strobe_ctl_n = 1; step_n = 0; wdata = 32'hA0A0A031; step();
    shadow[6'h31] = 32'hA0A0A031; idle();
    cpu_read("R4 own-cycle write", 6'h30);
    cpu_read("R4 extended write", 6'h31);

    // R8: lane masking and disabled lane writes
    ctl_write(6'h00, 32'h11223344, 1, 0, 4'b1010);
    cpu_read("R8 lanes 0 and 2", 6'h00);
    check("R8 merged value", {1'b0, shadow[6'h00]}, {1'b0, 32'h0A220C44});
    ctl_write(6'h00, 32'h99999999, 1, 1, 4'h0);
    cpu_read("R8 no write when lane enable high", 6'h00);

    // R9: full-word writes both ways
    ctl_write(6'h15, 32'h09090909, 1, 0, 4'h0);
    cpu_read("R9 all lanes selected", 6'h15);
    ctl_write(6'h15, 32'h19191919, 0, 0, 4'hF);
    cpu_read("R9 global write", 6'h15);

    // R11: output enable acts between edges
    strobe_cpu_n = 0; addr = 6'h01; step(); idle(); step();
    expect_word("R11 driven", shadow[6'h01]);
    out_en_n = 1; #0.5;
    check("R11 released", {rvalid, rdata}, 33'd0);
    out_en_n = 0; #0.5;
    expect_word("R11 re-enabled", shadow[6'h01]);

    // R1: mid-burst reset
    idle(); strobe_cpu_n = 0; addr = 6'h10; step(); idle(); step_n = 0;
    rst = 1; step();
    check("R1 mid-run reset", {32'b0, rvalid}, 33'd0);
    rst = 0; step(); step();
    check("R1 burst not resumed", {32'b0, rvalid}, 33'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule